// File: doc/BRIEF.md
# Reset-Time Debug Entry Sampler

This block decides, once per reset, two things about the processor's debug behaviour. The first is whether debug mode is permitted at all. The second is whether the processor should halt in debug mode before its first instruction or fetch from the reset vector as usual. It watches a single external debug pin and the processor's reset-output level. It samples the pin twice, at two fixed points around the moment that reset output is released.

The first sample is taken on the last clock edge at which the reset output is still high. That sample becomes a sticky `debug_enable` level, which holds until the next release of reset. The second sample is taken exactly `DELAY` clock edges after the release is first seen, where `DELAY` defaults to eight. It produces a single one-cycle pulse: either `enter_debug` or `start_normal`. If reset is asserted again, the pending decision is cancelled and both sampling points are re-armed. Watchpoint and breakpoint event lines pass through the block untouched, so a software monitor keeps them whatever the enable says.

Top module: `dbg_boot_sampler`

## Requirements
- R1: While `rst_n` is low, `debug_enable`, `enter_debug` and `start_normal` are all 0.
- R2: The release edge is the first rising clock edge at which `rst_out` is 0 after an edge at which it was 1. From the release edge on, `debug_enable` equals the level of `dbg_pin` at the edge just before the release edge (1 = enabled). The pin level at the release edge itself has no effect.
- R3: `debug_enable` changes only at a release edge. It keeps its value while `rst_out` is high again and for any time after the decision.
- R4: The second sample is the level of `dbg_pin` at the edge `DELAY` edges after the release edge (edge N+8 by default). The resulting pulse is high for the one cycle that follows that edge. Pin levels at the other edges do not affect it.
- R5: A second sample of 0 gives a `start_normal` pulse.
- R6: A second sample of 1 with `debug_enable` at 1 gives an `enter_debug` pulse.
- R7: A second sample of 1 with `debug_enable` at 0 is ignored, and a `start_normal` pulse is given.
- R8: Each release gives exactly one pulse of one cycle. No further pulse follows until a new release.
- R9: If `rst_out` is 1 at any edge before the second sample, the pending decision is cancelled and no pulse is given. The next release starts the sequence again.
- R10: `watch_out` equals `watch_in` at all times, whatever the value of `debug_enable`.
- R11: `enter_debug` and `start_normal` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset of this block |
| rst_out | input | 1 | Processor reset-output level, 1 while held in reset |
| dbg_pin | input | 1 | External debug pin, sampled twice per reset release |
| watch_in | input | WATCH_W | Watchpoint/breakpoint event lines from the trigger logic |
| debug_enable | output | 1 | Sticky debug-mode permission |
| enter_debug | output | 1 | One-cycle request to halt in debug mode before the first instruction |
| start_normal | output | 1 | One-cycle request to begin execution at the reset vector |
| watch_out | output | WATCH_W | Watchpoint/breakpoint events, passed on unconditionally |

## Verification
Call the release edge N. `debug_enable` takes its new value at edge N and can be read right after it. The pulse is due only in the cycle after edge N+8, and every other cycle in the window must be quiet. The bench changes inputs only at falling edges. After each rising edge N+k it reads all outputs at the next falling edge and compares them against the expected value for that exact k. It drives the opposite pin level on every edge except the two sampling edges, so a sample taken one edge early or late shows up as a wrong pulse or a wrong enable.

// File: rtl/dbg_boot_pkg.sv
package dbg_boot_pkg;

    // Phase of the post-release delay timer.
    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,   // waiting for a reset release
        TMR_RUN  = 2'd1,   // counting toward the second sample
        TMR_DONE = 2'd2    // decision issued, wait for reset again
    } tmr_state_e;

    // Outcome of the second sample.
    typedef enum logic [1:0] {
        BOOT_NONE   = 2'd0,
        BOOT_NORMAL = 2'd1,
        BOOT_DEBUG  = 2'd2
    } boot_kind_e;

endpackage

// File: rtl/dbg_rst_watch.sv
// Tracks the reset-output level, flags its release and holds the pin
// level seen on the most recent edge while reset was still asserted.
module dbg_rst_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_out,
    input  logic dbg_pin,
    output logic release_evt,
    output logic held_pin
);

    typedef struct packed {
        logic rst_seen;
        logic pin_shadow;
    } watch_t;

    watch_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rst_seen = rst_out;
        if (rst_out) begin
            st_d.pin_shadow = dbg_pin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign release_evt = st_q.rst_seen && !rst_out;
    assign held_pin    = st_q.pin_shadow;

endmodule

// File: rtl/dbg_delay_timer.sv
// Counts DELAY edges from the release edge and raises fire_now on the
// edge at which the second sample must be taken.
module dbg_delay_timer
    import dbg_boot_pkg::*;
#(
    parameter int DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic fire_now
);

    localparam int CNT_W = (DELAY > 2) ? $clog2(DELAY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

    typedef struct packed {
        tmr_state_e       phase;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic fire_d;

    always_comb begin
        st_d   = st_q;
        fire_d = 1'b0;
        unique case (st_q.phase)
            TMR_IDLE: begin
                if (start) begin
                    st_d.phase = TMR_RUN;
                    st_d.cnt   = '0;
                end
            end
            TMR_RUN: begin
                if (abort) begin
                    st_d.phase = TMR_IDLE;
                end else if (st_q.cnt == LAST) begin
                    fire_d     = 1'b1;
                    st_d.phase = TMR_DONE;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            TMR_DONE: begin
                if (abort) begin
                    st_d.phase = TMR_IDLE;
                end
            end
            default: begin
                st_d.phase = TMR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: TMR_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_now = fire_d;

endmodule

// File: rtl/dbg_entry_decide.sv
// Holds the sticky enable and turns the second sample into one pulse.
module dbg_entry_decide
    import dbg_boot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic release_evt,
    input  logic held_pin,
    input  logic fire_now,
    input  logic dbg_pin,
    output logic enable,
    output logic go_debug,
    output logic go_normal
);

    typedef struct packed {
        logic       en;
        boot_kind_e kind;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kind = BOOT_NONE;
        if (release_evt) begin
            st_d.en = held_pin;
        end
        if (fire_now) begin
            if (dbg_pin && st_q.en) begin
                st_d.kind = BOOT_DEBUG;
            end else begin
                st_d.kind = BOOT_NORMAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, kind: BOOT_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign enable    = st_q.en;
    assign go_debug  = (st_q.kind == BOOT_DEBUG);
    assign go_normal = (st_q.kind == BOOT_NORMAL);

endmodule

// File: rtl/dbg_boot_sampler.sv
module dbg_boot_sampler #(
    parameter int DELAY   = 8,
    parameter int WATCH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_out,
    input  logic               dbg_pin,
    input  logic [WATCH_W-1:0] watch_in,
    output logic               debug_enable,
    output logic               enter_debug,
    output logic               start_normal,
    output logic [WATCH_W-1:0] watch_out
);

    logic release_evt;
    logic held_pin;
    logic fire_now;

    dbg_rst_watch u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_out     (rst_out),
        .dbg_pin     (dbg_pin),
        .release_evt (release_evt),
        .held_pin    (held_pin)
    );

    dbg_delay_timer #(.DELAY(DELAY)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (release_evt),
        .abort    (rst_out),
        .fire_now (fire_now)
    );

    dbg_entry_decide u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .release_evt (release_evt),
        .held_pin    (held_pin),
        .fire_now    (fire_now),
        .dbg_pin     (dbg_pin),
        .enable      (debug_enable),
        .go_debug    (enter_debug),
        .go_normal   (start_normal)
    );

    // Trigger events are never gated by the debug permission.
    assign watch_out = watch_in;

endmodule

// File: rtl/dbg_boot_sampler_sva.sv
module dbg_boot_sampler_sva #(
    parameter int DELAY   = 8,
    parameter int WATCH_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rst_out,
    input logic               dbg_pin,
    input logic [WATCH_W-1:0] watch_in,
    input logic               debug_enable,
    input logic               enter_debug,
    input logic               start_normal,
    input logic [WATCH_W-1:0] watch_out
);

    localparam int SC_W = $clog2(DELAY + 3);
    localparam logic [SC_W-1:0] SC_MAX = SC_W'(DELAY + 2);
    localparam logic [SC_W-1:0] SC_DUE = SC_W'(DELAY + 1);

    logic            chk_rst_q;
    logic            chk_pin_q;
    logic [SC_W-1:0] since_q;
    logic            released;

    assign released = chk_rst_q && !rst_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_rst_q <= 1'b0;
            chk_pin_q <= 1'b0;
            since_q   <= '0;
        end else begin
            chk_rst_q <= rst_out;
            chk_pin_q <= dbg_pin;
            if (rst_out) begin
                since_q <= '0;
            end else if (released) begin
                since_q <= SC_W'(1);
            end else if (since_q != '0 && since_q != SC_MAX) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            p_quiet_in_reset_r1: assert (!debug_enable && !enter_debug && !start_normal);
        end
    end

    p_enable_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        released |=> (debug_enable == $past(chk_pin_q)));

    p_enable_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !released |=> $stable(debug_enable));

    p_pulse_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_debug || start_normal) |-> (since_q == SC_DUE));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_debug || start_normal) |=> !(enter_debug || start_normal));

    p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> !(enter_debug || start_normal));

    p_debug_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enter_debug |-> debug_enable);

    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enter_debug, start_normal}));

    // R10
    always @(posedge clk) begin
        p_watch_pass_r10: assert (watch_out == watch_in);
    end

endmodule

bind dbg_boot_sampler dbg_boot_sampler_sva #(.DELAY(DELAY), .WATCH_W(WATCH_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_out      (rst_out),
    .dbg_pin      (dbg_pin),
    .watch_in     (watch_in),
    .debug_enable (debug_enable),
    .enter_debug  (enter_debug),
    .start_normal (start_normal),
    .watch_out    (watch_out)
);

// File: tb/dbg_boot_sampler_tb.sv
`timescale 1ns/1ps
module dbg_boot_sampler_tb;

    localparam int DELAY   = 8;
    localparam int WATCH_W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rst_out = 1'b1;
    logic               dbg_pin = 1'b0;
    logic [WATCH_W-1:0] watch_in = '0;
    logic               debug_enable;
    logic               enter_debug;
    logic               start_normal;
    logic [WATCH_W-1:0] watch_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dbg_boot_sampler #(.DELAY(DELAY), .WATCH_W(WATCH_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_out      (rst_out),
        .dbg_pin      (dbg_pin),
        .watch_in     (watch_in),
        .debug_enable (debug_enable),
        .enter_debug  (enter_debug),
        .start_normal (start_normal),
        .watch_out    (watch_out)
    );

    // {pin before release, pin at second sample, exp enable, exp enter, exp start}
    localparam logic [4:0] VEC [0:5] = '{
        5'b11_110,   // R6
        5'b10_101,   // R5
        5'b01_001,   // R7
        5'b00_001,   // R5
        5'b11_110,   // R2 re-enable after a disabled boot
        5'b01_001    // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulses_quiet(input string req);
        chk(req, {30'd0, enter_debug, start_normal}, 32'd0);
    endtask

    // Full boot with per-edge checks; release edge is N, sample at N+DELAY.
    task automatic boot(input logic rp, input logic sp, input logic xen,
                        input logic xent, input logic xst);
        rst_out = 1'b1;
        dbg_pin = rp;
        repeat (3) @(negedge clk);
        rst_out = 1'b0;
        dbg_pin = ~rp;                  // level at edge N must not matter (R2)
        for (int k = 0; k < DELAY + 4; k++) begin
            @(negedge clk);             // just after edge N+k
            chk("R2 enable", debug_enable, xen);
            if (k == DELAY) begin
                chk("R6 enter_debug", enter_debug, xent);
                chk("R5/R7 start_normal", start_normal, xst);
            end else begin
                pulses_quiet("R4/R8 no pulse off the sample edge");
            end
            dbg_pin = (k + 1 == DELAY) ? sp : ~sp;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 enable in reset", debug_enable, 1'b0);
        pulses_quiet("R1 pulses in reset");
        dbg_pin = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 6; i++) begin
            boot(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R3: enable holds through a new reset assertion and a long run
        boot(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        chk("R3 enable after decision", debug_enable, 1'b1);
        pulses_quiet("R8 no second pulse");
        rst_out = 1'b1;
        dbg_pin = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk("R3 enable while reset reasserted", debug_enable, 1'b1);
            pulses_quiet("R9 no pulse during reset");
        end

        // R9: reset reasserted mid-count cancels the decision
        dbg_pin = 1'b1;
        @(negedge clk);
        rst_out = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            dbg_pin = 1'b1;
        end
        rst_out = 1'b1;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            pulses_quiet("R9 cancelled decision");
        end
        boot(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);   // R9 re-armed

        // R10: events pass regardless of enable
        watch_in = 4'hA;
        @(negedge clk);
        chk("R10 watch with enable=1", watch_out, 4'hA);
        boot(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        watch_in = 4'h5;
        @(negedge clk);
        chk("R10 watch with enable=0", watch_out, 4'h5);

        // R1: reset mid-life clears the enable
        boot(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 enable cleared by rst_n", debug_enable, 1'b0);
        pulses_quiet("R1 pulses cleared by rst_n");
        rst_n = 1'b1;
        @(negedge clk);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule